// File: doc/BRIEF.md
# Bypassing Carry-Save Array Multiplier

This block multiplies two unsigned operands in a carry-save array of full-adder cells, with a ripple-carry adder after the last row. The default operand width is 8 bits. Every cell in the array sits behind a bypass. A cell is bypassed when its own partial-product bit and the carry it receives from the row above are both zero. A bypassed cell adds nothing: its adder inputs are held quiet, it forwards the incoming partial sum unchanged, and its carry output is zero.

This merges skipping by multiplier row and skipping by multiplicand column into one condition per cell. Because that condition is exact, the product needs no correction after the array.

Operands are presented with a `valid_in` strobe. On that clock edge the product and the bypass state of every cell are stored in an output register. `valid_out` follows one clock later. An asynchronous active-low reset clears the outputs.

Top module: `byp_array_mult`

## Requirements
- R1: One clock edge after `valid_in` is high, `product` equals the arithmetic product `a_in * b_in` of the operands present at that edge (unsigned, full 2W bits).
- R2: `valid_out` is high in the cycle after an edge where `valid_in` was high, and low in the cycle after an edge where it was low.
- R3: While `rst_n` is low, `product`, `valid_out` and `bypass_map` are all zero, even if `valid_in` is high.
- R4: At an edge with `valid_in` low, `product` and `bypass_map` keep their previous values.
- R5: The cells of array row 1 receive no carry, so each bit i (for i from 0 to W-2) of the first W-1 bits of `bypass_map` equals NOT(a_i AND b_1).
- R6: Bit (j-1)*(W-1)+i of `bypass_map` is for row j (1..W-1) and column i (0..W-2). It is 1 exactly when a_i AND b_j is 0 and the carry reaching that cell from row j-1 is 0.
- R7: When either operand is zero, every bit of `bypass_map` is 1 and `product` is zero.
- R8: R1 holds for every one of the 2^(2W) operand pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Capture strobe for the operands |
| a_in | input | W | Multiplicand |
| b_in | input | W | Multiplier |
| product | output | 2W | Registered product |
| valid_out | output | 1 | Product valid, one cycle after capture |
| bypass_map | output | (W-1)*(W-1) | Registered bypass state, one bit per array cell |

## Verification
A capture by `valid_in` and an active reset can happen in the same cycle. The bench provokes this by holding `valid_in` high with operands 0xFF and 0xFF, both while reset is asserted and again when reset is pulsed in the middle of traffic. It judges the result by requiring all-zero outputs during reset. A second overlap is a new capture in the same cycle as a hold: `valid_in` is randomly gapped during the random phase. That phase checks that each captured product and bypass map survives the gap unchanged until the next strobe.

// File: rtl/byp_array_mult.sv
module byp_array_mult #(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid_in,
  input  logic [W-1:0]             a_in,
  input  logic [W-1:0]             b_in,
  output logic [2*W-1:0]           product,
  output logic                     valid_out,
  output logic [(W-1)*(W-1)-1:0]   bypass_map
);
  localparam int NC = (W-1)*(W-1);
  localparam int PW = 2*W;

  logic [W*W-1:0]     pp;
  logic [W*W-1:0]     s;
  logic [W*(W-1)-1:0] c;
  logic [NC-1:0]      byp;
  logic [W-1:0]       rc;
  logic [PW-1:0]      prod_c;

  genvar i, j;
  generate
    for (j = 0; j < W; j++) begin : g_pp_row
      for (i = 0; i < W; i++) begin : g_pp_col
        assign pp[j*W+i] = a_in[i] & b_in[j];
      end
    end

    for (i = 0; i < W; i++) begin : g_row0
      assign s[i] = pp[i];
    end
    assign c[W-2:0] = '0;

    for (j = 1; j < W; j++) begin : g_row
      for (i = 0; i < W-1; i++) begin : g_cell
        logic x, y, z, act;
        assign act = pp[j*W+i] | c[(j-1)*(W-1)+i];
        assign x   = act & pp[j*W+i];
        assign z   = act & c[(j-1)*(W-1)+i];
        assign y   = s[(j-1)*W+i+1];
        assign byp[(j-1)*(W-1)+i] = ~act;
        assign s[j*W+i]     = act ? (x ^ y ^ z) : y;
        assign c[j*(W-1)+i] = act & ((x & y) | (x & z) | (y & z));
      end
      assign s[j*W+W-1] = pp[j*W+W-1];
    end

    for (j = 0; j < W; j++) begin : g_lo
      assign prod_c[j] = s[j*W];
    end

    assign rc[0] = 1'b0;
    for (i = 0; i < W-1; i++) begin : g_rca
      logic x, z;
      assign x = s[(W-1)*W+i+1];
      assign z = c[(W-1)*(W-1)+i];
      assign prod_c[W+i] = x ^ z ^ rc[i];
      assign rc[i+1]     = (x & z) | (x & rc[i]) | (z & rc[i]);
    end
    assign prod_c[PW-1] = rc[W-1];
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product    <= '0;
      valid_out  <= 1'b0;
      bypass_map <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        product    <= prod_c;
        bypass_map <= byp;
      end
    end
  end
endmodule

// File: rtl/byp_array_mult_chk.sv
module byp_array_mult_chk #(
  parameter int W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   valid_in,
  input logic [W-1:0]           a_in,
  input logic [W-1:0]           b_in,
  input logic [2*W-1:0]         product,
  input logic                   valid_out,
  input logic [(W-1)*(W-1)-1:0] bypass_map
);
  localparam int PW = 2*W;

  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> product == PW'($past(a_in)) * PW'($past(b_in)));

  a_r2_valid_hi: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);

  a_r2_valid_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);

  always @(negedge clk) begin
    if (!rst_n) begin
      a_r3_reset_clear: assert (product == '0 && !valid_out && bypass_map == '0);
    end
  end

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(product) && $stable(bypass_map));

  a_r5_row1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> bypass_map[W-2:0] == ~($past(a_in[W-2:0]) & {(W-1){$past(b_in[1])}}));

  a_r7_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && (a_in == '0 || b_in == '0)) |=> (&bypass_map) && product == '0);
endmodule

bind byp_array_mult byp_array_mult_chk #(.W(W)) u_chk (.*);

// File: tb/tb_byp_array_mult.sv
module tb_byp_array_mult;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int NC = (W-1)*(W-1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_in = 1'b0;
  logic [W-1:0]  a_in = '0;
  logic [W-1:0]  b_in = '0;
  logic [2*W-1:0] product;
  logic          valid_out;
  logic [NC-1:0] bypass_map;

  int vectors = 0;
  int fails = 0;
  logic [2*W-1:0] exp_prod = '0;
  logic [NC-1:0]  exp_map = '0;
  logic           exp_vout = 1'b0;

  byp_array_mult #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .a_in(a_in), .b_in(b_in),
    .product(product), .valid_out(valid_out), .bypass_map(bypass_map)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NC-1:0] ref_map(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [NC-1:0] m;
    logic [W-1:0] sp, sn;
    logic [W-2:0] cp, cn;
    logic x, y, z;
    m = '0;
    sp = a & {W{b[0]}};
    cp = '0;
    for (int j = 1; j < W; j++) begin
      for (int i = 0; i < W-1; i++) begin
        x = a[i] & b[j];
        y = sp[i+1];
        z = cp[i];
        m[(j-1)*(W-1)+i] = !(x | z);
        sn[i] = x ^ y ^ z;
        cn[i] = (x & y) | (x & z) | (y & z);
      end
      sn[W-1] = a[W-1] & b[j];
      sp = sn;
      cp = cn;
    end
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic compare(input string tag);
    chk(product == exp_prod, {tag, " product R1/R4/R8"}, 64'(product), 64'(exp_prod));
    chk(bypass_map == exp_map, {tag, " bypass map R6/R4"}, 64'(bypass_map), 64'(exp_map));
    chk(valid_out == exp_vout, {tag, " valid_out R2"}, 64'(valid_out), 64'(exp_vout));
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic v, input string tag);
    @(negedge clk);
    compare(tag);
    exp_vout = v;
    if (v) begin
      exp_prod = (2*W)'(a) * (2*W)'(b);
      exp_map  = ref_map(a, b);
    end
    a_in = a; b_in = b; valid_in = v;
  endtask

  task automatic check_reset(input string tag);
    chk(product == '0 && valid_out == 1'b0 && bypass_map == '0, {tag, " R3 reset clear"},
        64'(product), 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb;
    logic rv;
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    // R3: valid_in high during reset must not load
    a_in = 8'hFF; b_in = 8'hFF; valid_in = 1'b1;
    repeat (3) @(negedge clk);
    check_reset("initial");
    rst_n = 1'b1;
    valid_in = 1'b0;
    exp_prod = '0; exp_map = '0; exp_vout = 1'b0;

    // directed corners
    apply(8'hFF, 8'hFF, 1'b1, "max x max");
    apply(8'h00, 8'hA5, 1'b1, "R7 a zero");
    apply(8'h00, 8'hA5, 1'b0, "hold");
    @(negedge clk);
    chk(&bypass_map, "R7 all bypassed a=0", 64'(bypass_map), 64'(exp_map));
    apply(8'h5A, 8'h00, 1'b1, "R7 b zero");
    apply(8'h01, 8'h01, 1'b1, "one x one");
    apply(8'h80, 8'h80, 1'b1, "msb x msb");
    apply(8'h7F, 8'h02, 1'b1, "R5 row1");
    @(negedge clk);
    chk(bypass_map[W-2:0] == 7'h00, "R5 row1 active cells", 64'(bypass_map[W-2:0]), 64'h0);
    apply(8'h55, 8'hAA, 1'b1, "alt bits");

    // R8 exhaustive, back to back
    for (int k = 0; k < 65536; k++) begin
      apply(k[15:8], k[7:0], 1'b1, "R8 exhaustive");
    end

    // random with gaps (R4 hold)
    for (int k = 0; k < 3000; k++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      rv = 1'($urandom % 3 != 0);
      if (k % 97 == 0) rb = '0;
      apply(ra, rb, rv, "random");
    end

    // reset pulse during traffic with capture pending
    apply(8'hFF, 8'hFF, 1'b1, "pre reset");
    @(negedge clk);
    compare("pre reset");
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset("mid traffic");
    @(negedge clk);
    check_reset("mid traffic held");
    rst_n = 1'b1;
    valid_in = 1'b0;
    exp_prod = '0; exp_map = '0; exp_vout = 1'b0;
    apply(8'hC3, 8'h3C, 1'b1, "after reset");
    apply(8'h00, 8'h00, 1'b0, "after reset hold");
    @(negedge clk);
    compare("final");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule